// File: doc/BRIEF.md
# Two-Way Byte Mailbox with Four-Phase Handshake

This block connects two processor buses, called side A and side B, so that each side can pass blocks of bytes to the other. There is one channel per direction. A channel holds a byte latch, an interrupt request, a ready-for-data flag, a data-valid flag, a data-accepted flag and a sticky overrun flag. It also has a small state machine that counts the bytes of the block. Each side reaches its registers through a byte-wide bus with a write strobe, a read strobe and a 3-bit address. The same address map serves both sides. On each side, "outbound" means the channel this side sends on, and "inbound" means the channel it receives on.

The sending side always starts a block. It first raises an interrupt to the peer. The peer clears that interrupt, then paces every byte with a four-phase exchange:
1. The receiver raises ready.
2. The sender loads the latch and raises valid.
3. The receiver drops ready, reads the byte and pulses accept.
4. The sender drops valid, which also withdraws accept.

The first byte accepted after the interrupt gives the number of bytes that follow.

Address map, the same on both sides:

| Address | Write | Read |
|---|---|---|
| 0 | load the outbound latch | the inbound latch |
| 1 | (none) | status |
| 2 | inbound ready takes wdata[0] | (none) |
| 3 | outbound valid takes wdata[0] | (none) |
| 4 | pulse inbound accept | (none) |
| 5 | raise outbound interrupt if wdata[0]=1 | (none) |
| 6 | clear inbound interrupt if wdata[0]=0 | (none) |
| 7 | (none) | inbound remaining count |

Status bits:

| Bit | Meaning |
|---|---|
| 7 | inbound interrupt |
| 6 | inbound valid |
| 5 | outbound ready (the peer is ready) |
| 4 | outbound accept |
| 3 | outbound overrun |
| 2 | inbound done |
| 1 | outbound done |
| 0 | outbound valid |

Each channel's counting state machine has four states:
- CH_IDLE: no block has started since reset.
- CH_LEN: the channel is waiting for the length byte.
- CH_BODY: payload bytes remain.
- CH_DONE: the block is complete.

Its transitions are:
- START: from any state to CH_LEN, on the sender's interrupt-raise write.
- LEN_ZERO: CH_LEN to CH_DONE, when the accepted length byte is 0.
- LEN_LOAD: CH_LEN to CH_BODY, when the accepted length byte is not 0.
- BODY_STEP: CH_BODY to CH_BODY, on an accepted byte while more than one remains.
- BODY_LAST: CH_BODY to CH_DONE, on the accepted byte that brings the count to zero.

START takes priority over an accept in the same cycle.

Top module: `mbx_top`

## Requirements
- R1: When the synchronous active-high reset is asserted, every flag and counter is cleared. Both interrupt outputs are 0, and status and count read 0 on both sides.
- R2: A sender write to address 5 with wdata[0]=1 raises the peer's interrupt output from the next cycle. The peer also sees the interrupt as status bit 7.
- R3: A receiver write to address 6 with wdata[0]=0 clears its inbound interrupt. The same write with wdata[0]=1 leaves the interrupt set.
- R4: A receiver write to address 2 stores wdata[0] as its inbound ready flag. The sender sees that flag as status bit 5.
- R5: A sender write to address 0 loads the outbound latch, and a write to address 3 stores wdata[0] as outbound valid. The receiver sees valid as status bit 6 and reads the byte at address 0.
- R6: A receiver write to address 4 while inbound valid is set clears inbound ready and sets accept. The sender sees accept as status bit 4. When valid is clear, the write has no effect.
- R7: A sender write of 0 to address 3 clears both valid and accept.
- R8: The first byte accepted after an interrupt raise is taken as the block length. The receiver reads the remaining count at address 7.
- R9: Each payload byte accepted afterwards lowers the count by one. When the count reaches 0, done is set: status bit 2 on the receiving side and bit 1 on the sending side.
- R10: A length byte of 0 sets done immediately, and the count stays at 0.
- R11: A write to address 0 while outbound valid is set leaves the latch unchanged and sets a sticky overrun flag, seen as status bit 3. Only reset clears this flag.
- R12: The two directions are independent. Activity in one direction leaves the other direction's flags, latch and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe; a_rdata is 0 when this is low |
| a_addr | input | 3 | Side A register address |
| a_wdata | input | 8 | Side A write data |
| a_rdata | output | 8 | Side A read data |
| a_irq | output | 1 | Interrupt to side A (from the B-to-A channel) |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe; b_rdata is 0 when this is low |
| b_addr | input | 3 | Side B register address |
| b_wdata | input | 8 | Side B write data |
| b_rdata | output | 8 | Side B read data |
| b_irq | output | 1 | Interrupt to side B (from the A-to-B channel) |

## Verification
The bench builds the block with its default 8-bit data width, so the latch, the length byte and the remaining count are all the full byte. Block lengths from 0 up to several bytes are therefore covered, and a zero length exercises the immediate-done path. A 3-bit address reaches all eight registers on each side. This allows every flag to be walked through complete transfers in both directions, random in length and payload. Around those transfers, directed cases exercise overrun, an accept with no byte pending, a clear written with the wrong level, and a half-started block in one direction left standing while the other direction runs.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int ADDR_W = 3;

    // register addresses, identical on both sides
    localparam logic [ADDR_W-1:0] RG_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] RG_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] RG_RDY  = 3'd2;
    localparam logic [ADDR_W-1:0] RG_VLD  = 3'd3;
    localparam logic [ADDR_W-1:0] RG_ACK  = 3'd4;
    localparam logic [ADDR_W-1:0] RG_IRQ  = 3'd5;
    localparam logic [ADDR_W-1:0] RG_ICLR = 3'd6;
    localparam logic [ADDR_W-1:0] RG_CNT  = 3'd7;

    // status bit positions
    localparam int SB_IN_IRQ   = 7;
    localparam int SB_IN_VLD   = 6;
    localparam int SB_OUT_RDY  = 5;
    localparam int SB_OUT_ACK  = 4;
    localparam int SB_OUT_OVR  = 3;
    localparam int SB_IN_DONE  = 2;
    localparam int SB_OUT_DONE = 1;
    localparam int SB_OUT_VLD  = 0;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_LEN  = 2'd1,
        CH_BODY = 2'd2,
        CH_DONE = 2'd3
    } ch_state_e;

endpackage

// File: rtl/mbx_chan.sv
module mbx_chan
    import mbx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    // sender side controls
    input  logic          snd_irq_set,
    input  logic          snd_data_wr,
    input  logic          snd_vld_wr,
    input  logic          snd_vld_lvl,
    input  logic [DW-1:0] snd_wdata,
    // receiver side controls
    input  logic          rcv_rdy_wr,
    input  logic          rcv_rdy_lvl,
    input  logic          rcv_ack_pls,
    input  logic          rcv_irq_clr,
    // state
    output logic [DW-1:0] latch_q,
    output logic          irq_q,
    output logic          rdy_q,
    output logic          vld_q,
    output logic          ack_q,
    output logic          ovr_q,
    output logic [DW-1:0] cnt_q,
    output logic          done
);

    localparam logic [DW-1:0] CNT_ONE = DW'(1);

    ch_state_e state_q, state_d;
    logic      accept;

    assign accept = rcv_ack_pls && vld_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CH_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (snd_irq_set) begin
            state_d = CH_LEN;                          // START
        end else begin
            unique case (state_q)
                CH_IDLE: state_d = CH_IDLE;
                CH_LEN: begin
                    if (accept) begin
                        if (latch_q == '0) state_d = CH_DONE;   // LEN_ZERO
                        else               state_d = CH_BODY;   // LEN_LOAD
                    end
                end
                CH_BODY: begin
                    if (accept && cnt_q == CNT_ONE) state_d = CH_DONE; // BODY_LAST
                end
                CH_DONE: state_d = CH_DONE;
                default: state_d = CH_IDLE;
            endcase
        end
    end

    // counter
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (snd_irq_set) begin
            cnt_q <= '0;
        end else if (accept) begin
            unique case (state_q)
                CH_LEN:  cnt_q <= latch_q;
                CH_BODY: cnt_q <= cnt_q - CNT_ONE;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // data latch and overrun
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            ovr_q   <= 1'b0;
        end else if (snd_data_wr) begin
            if (vld_q) ovr_q   <= 1'b1;
            else       latch_q <= snd_wdata;
        end
    end

    // interrupt request
    always_ff @(posedge clk) begin
        if (rst)              irq_q <= 1'b0;
        else if (snd_irq_set) irq_q <= 1'b1;
        else if (rcv_irq_clr) irq_q <= 1'b0;
    end

    // handshake flags
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q <= 1'b0;
            vld_q <= 1'b0;
            ack_q <= 1'b0;
        end else begin
            if (accept)          rdy_q <= 1'b0;
            else if (rcv_rdy_wr) rdy_q <= rcv_rdy_lvl;

            if (snd_vld_wr) vld_q <= snd_vld_lvl;

            if (snd_vld_wr && !snd_vld_lvl) ack_q <= 1'b0;
            else if (accept)                ack_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        done = 1'b0;
        unique case (state_q)
            CH_DONE: done = 1'b1;
            default: done = 1'b0;
        endcase
    end

endmodule

// File: rtl/mbx_port.sv
module mbx_port
    import mbx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    // strobes toward the outbound channel
    output logic              out_irq_set,
    output logic              out_data_wr,
    output logic              out_vld_wr,
    // strobes toward the inbound channel
    output logic              in_rdy_wr,
    output logic              in_ack_pls,
    output logic              in_irq_clr,
    // state of the outbound channel
    input  logic              out_rdy,
    input  logic              out_vld,
    input  logic              out_ack,
    input  logic              out_ovr,
    input  logic              out_done,
    // state of the inbound channel
    input  logic [DW-1:0]     in_latch,
    input  logic              in_irq,
    input  logic              in_vld,
    input  logic              in_done,
    input  logic [DW-1:0]     in_cnt
);

    logic [DW-1:0] stat;

    // write decode
    always_comb begin
        out_irq_set = 1'b0;
        out_data_wr = 1'b0;
        out_vld_wr  = 1'b0;
        in_rdy_wr   = 1'b0;
        in_ack_pls  = 1'b0;
        in_irq_clr  = 1'b0;
        if (wr) begin
            unique case (addr)
                RG_DATA: out_data_wr = 1'b1;
                RG_RDY:  in_rdy_wr   = 1'b1;
                RG_VLD:  out_vld_wr  = 1'b1;
                RG_ACK:  in_ack_pls  = 1'b1;
                RG_IRQ:  out_irq_set = wdata[0];
                RG_ICLR: in_irq_clr  = !wdata[0];
                default: ;
            endcase
        end
    end

    // status word
    always_comb begin
        stat              = '0;
        stat[SB_IN_IRQ]   = in_irq;
        stat[SB_IN_VLD]   = in_vld;
        stat[SB_OUT_RDY]  = out_rdy;
        stat[SB_OUT_ACK]  = out_ack;
        stat[SB_OUT_OVR]  = out_ovr;
        stat[SB_IN_DONE]  = in_done;
        stat[SB_OUT_DONE] = out_done;
        stat[SB_OUT_VLD]  = out_vld;
    end

    // read mux
    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (addr)
                RG_DATA: rdata = in_latch;
                RG_STAT: rdata = stat;
                RG_CNT:  rdata = in_cnt;
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mbx_top.sv
module mbx_top
    import mbx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DW-1:0]     a_wdata,
    output logic [DW-1:0]     a_rdata,
    output logic              a_irq,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DW-1:0]     b_wdata,
    output logic [DW-1:0]     b_rdata,
    output logic              b_irq
);

    localparam int NS = 2;   // side 0 = A, side 1 = B; channel k sends from side k

    logic [NS-1:0]              wr_s, rd_s;
    logic [NS-1:0][ADDR_W-1:0]  addr_s;
    logic [NS-1:0][DW-1:0]      wdata_s, rdata_s;

    logic [NS-1:0]              irq_set_s, data_wr_s, vld_wr_s;
    logic [NS-1:0]              rdy_wr_s, ack_pls_s, irq_clr_s;
    logic [NS-1:0][DW-1:0]      latch_q, cnt_q;
    logic [NS-1:0]              irq_q, rdy_q, vld_q, ack_q, ovr_q, done_s;

    assign wr_s    = {b_wr, a_wr};
    assign rd_s    = {b_rd, a_rd};
    assign addr_s  = {b_addr, a_addr};
    assign wdata_s = {b_wdata, a_wdata};
    assign a_rdata = rdata_s[0];
    assign b_rdata = rdata_s[1];
    assign a_irq   = irq_q[1];
    assign b_irq   = irq_q[0];

    for (genvar k = 0; k < NS; k++) begin : g_side
        localparam int PEER = NS - 1 - k;

        mbx_chan #(.DW(DW)) u_chan (
            .clk         (clk),
            .rst         (rst),
            .snd_irq_set (irq_set_s[k]),
            .snd_data_wr (data_wr_s[k]),
            .snd_vld_wr  (vld_wr_s[k]),
            .snd_vld_lvl (wdata_s[k][0]),
            .snd_wdata   (wdata_s[k]),
            .rcv_rdy_wr  (rdy_wr_s[k]),
            .rcv_rdy_lvl (wdata_s[PEER][0]),
            .rcv_ack_pls (ack_pls_s[k]),
            .rcv_irq_clr (irq_clr_s[k]),
            .latch_q     (latch_q[k]),
            .irq_q       (irq_q[k]),
            .rdy_q       (rdy_q[k]),
            .vld_q       (vld_q[k]),
            .ack_q       (ack_q[k]),
            .ovr_q       (ovr_q[k]),
            .cnt_q       (cnt_q[k]),
            .done        (done_s[k])
        );

        mbx_port #(.DW(DW)) u_port (
            .wr          (wr_s[k]),
            .rd          (rd_s[k]),
            .addr        (addr_s[k]),
            .wdata       (wdata_s[k]),
            .rdata       (rdata_s[k]),
            .out_irq_set (irq_set_s[k]),
            .out_data_wr (data_wr_s[k]),
            .out_vld_wr  (vld_wr_s[k]),
            .in_rdy_wr   (rdy_wr_s[PEER]),
            .in_ack_pls  (ack_pls_s[PEER]),
            .in_irq_clr  (irq_clr_s[PEER]),
            .out_rdy     (rdy_q[k]),
            .out_vld     (vld_q[k]),
            .out_ack     (ack_q[k]),
            .out_ovr     (ovr_q[k]),
            .out_done    (done_s[k]),
            .in_latch    (latch_q[PEER]),
            .in_irq      (irq_q[PEER]),
            .in_vld      (vld_q[PEER]),
            .in_done     (done_s[PEER]),
            .in_cnt      (cnt_q[PEER])
        );
    end

endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
    parameter int DW = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 a_irq,
    input logic                 b_irq,
    input logic [1:0]           irq_set_s,
    input logic [1:0]           data_wr_s,
    input logic [1:0]           ack_pls_s,
    input logic [1:0][DW-1:0]   latch_q,
    input logic [1:0][DW-1:0]   cnt_q,
    input logic [1:0]           vld_q,
    input logic [1:0]           ack_q,
    input logic [1:0]           rdy_q,
    input logic [1:0]           ovr_q,
    input logic [1:0]           done_s
);

    for (genvar k = 0; k < 2; k++) begin : g_chk
        // R1
        rst_clear_chk: assert property (@(posedge clk)
            rst |=> (!vld_q[k] && !ack_q[k] && !rdy_q[k] && !ovr_q[k] && cnt_q[k] == '0));

        // R11
        ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            ovr_q[k] |=> ovr_q[k]);

        // R11
        latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
            vld_q[k] |=> $stable(latch_q[k]));

        // R6
        ack_needs_vld_chk: assert property (@(posedge clk) disable iff (rst)
            ack_q[k] |-> vld_q[k]);

        // R6
        ack_drops_rdy_chk: assert property (@(posedge clk) disable iff (rst)
            (ack_pls_s[k] && vld_q[k]) |=> (!rdy_q[k] && ack_q[k]));

        // R9
        done_zero_chk: assert property (@(posedge clk) disable iff (rst)
            done_s[k] |-> cnt_q[k] == '0);
    end

    // R2
    irq_b_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(b_irq) |-> $past(irq_set_s[0]));

    // R2
    irq_a_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(a_irq) |-> $past(irq_set_s[1]));

endmodule

bind mbx_top mbx_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .a_irq     (a_irq),
    .b_irq     (b_irq),
    .irq_set_s (irq_set_s),
    .data_wr_s (data_wr_s),
    .ack_pls_s (ack_pls_s),
    .latch_q   (latch_q),
    .cnt_q     (cnt_q),
    .vld_q     (vld_q),
    .ack_q     (ack_q),
    .rdy_q     (rdy_q),
    .ovr_q     (ovr_q),
    .done_s    (done_s)
);

// File: tb/sim_mbx_top.sv
module sim_mbx_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
    logic [2:0] a_addr = 0, b_addr = 0;
    logic [7:0] a_wdata = 0, b_wdata = 0;
    logic [7:0] a_rdata, b_rdata;
    logic       a_irq, b_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    mbx_top u0 (
        .clk(clk), .rst(rst),
        .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // write one register on side s (0 = A, 1 = B), taking effect at the next edge
    task automatic wr(input int s, input logic [2:0] ad, input logic [7:0] d);
        @(negedge clk);
        if (s == 0) begin a_wr = 1; a_addr = ad; a_wdata = d; end
        else        begin b_wr = 1; b_addr = ad; b_wdata = d; end
        @(negedge clk);
        a_wr = 0; b_wr = 0;
    endtask

    task automatic rd(input int s, input logic [2:0] ad, output logic [7:0] d);
        @(negedge clk);
        if (s == 0) begin a_rd = 1; a_addr = ad; end
        else        begin b_rd = 1; b_addr = ad; end
        #2;
        d = (s == 0) ? a_rdata : b_rdata;
        a_rd = 0; b_rd = 0;
    endtask

    function automatic bit irq_of(input int s);
        return (s == 0) ? a_irq : b_irq;
    endfunction

    // expected remaining count after byte i of a block of length n
    function automatic int exp_cnt(input int n, input int i);
        return (i == 0) ? n : n - i;
    endfunction

    // full block from side s to its peer
    task automatic xfer(input int s, input int n);
        int r = 1 - s;
        logic [7:0] v, b;
        wr(s, 3'd5, 8'h01);
        #1 check("R2 irq out", irq_of(r), 1);
        rd(r, 3'd1, v);
        check("R2 stat7", v[7], 1);
        wr(r, 3'd6, 8'h00);
        #1 check("R3 irq clr", irq_of(r), 0);
        for (int i = 0; i <= n; i++) begin
            b = (i == 0) ? 8'(n) : 8'($urandom_range(0, 255));
            wr(r, 3'd2, 8'h01);
            rd(s, 3'd1, v);
            check("R4 rdy seen", v[5], 1);
            wr(s, 3'd0, b);
            wr(s, 3'd3, 8'h01);
            rd(r, 3'd1, v);
            check("R5 vld seen", v[6], 1);
            rd(r, 3'd0, v);
            check("R5 data", v, b);
            wr(r, 3'd4, 8'h00);
            rd(s, 3'd1, v);
            check("R6 ack seen", v[4], 1);
            check("R6 rdy dropped", v[5], 0);
            wr(s, 3'd3, 8'h00);
            rd(s, 3'd1, v);
            check("R7 ack withdrawn", v[4], 0);
            rd(r, 3'd7, v);
            check(i == 0 ? "R8 len count" : "R9 count step", v, exp_cnt(n, i));
            rd(r, 3'd1, v);
            check(n == 0 ? "R10 zero done" : "R9 done rx", v[2], exp_cnt(n, i) == 0);
            rd(s, 3'd1, v);
            check("R9 done tx", v[1], exp_cnt(n, i) == 0);
        end
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        void'($urandom(32'd7));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1 reset state
        for (int s = 0; s < 2; s++) begin
            rd(s, 3'd1, v); check("R1 stat", v, 0);
            rd(s, 3'd7, v); check("R1 cnt", v, 0);
        end
        check("R1 irq a", a_irq, 0);
        check("R1 irq b", b_irq, 0);

        // directed: zero length and short blocks both ways
        xfer(0, 0);
        xfer(1, 3);

        // R6 accept without valid is ignored
        wr(1, 3'd2, 8'h01);
        wr(1, 3'd4, 8'h00);
        rd(0, 3'd1, v);
        check("R6 ack ignored", v[4], 0);
        check("R6 rdy kept", v[5], 1);
        wr(1, 3'd2, 8'h00);

        // R3 clear with bit0=1 ignored
        wr(0, 3'd5, 8'h01);
        wr(1, 3'd6, 8'h01);
        #1 check("R3 clr ignored", b_irq, 1);

        // R12 half-open A->B block survives a B->A block
        wr(0, 3'd0, 8'h5a);
        wr(0, 3'd3, 8'h01);
        xfer(1, 2);
        rd(1, 3'd0, v); check("R12 latch kept", v, 8'h5a);
        rd(1, 3'd1, v); check("R12 vld kept", v[6], 1);
        check("R12 irq kept", b_irq, 1);

        // R11 overrun
        wr(0, 3'd0, 8'ha5);
        rd(1, 3'd0, v); check("R11 latch held", v, 8'h5a);
        rd(0, 3'd1, v); check("R11 ovr set", v[3], 1);
        wr(0, 3'd3, 8'h00);
        rd(0, 3'd1, v); check("R11 ovr sticky", v[3], 1);
        rd(1, 3'd1, v); check("R11 ovr other dir", v[3], 0);

        // random blocks
        for (int t = 0; t < 12; t++)
            xfer(int'($urandom_range(0, 1)), int'($urandom_range(0, 6)));

        // R1 reset again clears sticky overrun
        @(negedge clk) rst = 1;
        @(negedge clk) rst = 0;
        rd(0, 3'd1, v); check("R1 reset ovr", v, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule